// File: doc/BRIEF.md
# E3 Transmit Serial Payload Input

This block sits at the system side of an E3 transmitter. Terminal equipment delivers payload one bit per clock on a serial input. The block merges those bits into a 1536-bit outbound frame and inserts the framing and overhead bits of each frame itself. A single locally supplied line-rate clock (nominally 34.368 MHz) times everything. The equipment changes its data on a rising edge, and the block latches that data on a rising edge.

A position counter runs across the frame. The first twelve positions are overhead: a ten-bit alignment pattern, then an alarm bit, then a national-use bit. The rest of the frame carries payload. The block gives the upstream equipment two signals. A stall indicator goes high one clock before every overhead position. While it is high, the equipment must hold its next payload bit back by one clock, so no payload bit is dropped. A frame marker pulses during the last position of each frame. The selected bit, either overhead or payload, leaves on the line output one clock after it is sampled.

Top module: `e3_tx_payload_in`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to position 0, and `line_out`, `stall_ind` and `frame_last` read 0 in the following cycle.
- R2: Out of reset, `frame_last` pulses once every 1536 clocks.
- R3: `frame_last` is high for exactly one clock, in the cycle that processes position 1535. That cycle is the 1535th clock after the first clock with reset released.
- R4: `stall_ind` is high in the cycle that processes positions 1535 and 0 through 10. Each of those cycles is the clock just before an overhead position. It is low in every other cycle.
- R5: Because the frame begins with overhead, `stall_ind` and `frame_last` are high together in the cycle that processes the last position.
- R6: At payload positions 12 through 1535, `line_out` shows the `pay_in` value sampled at the rising edge that ends that position's cycle, one clock later.
- R7: Positions 0 through 9 put the alignment pattern on `line_out`, first bit first: 1,1,1,1,0,1,0,0,0,0.
- R8: Position 10 puts the `alarm_in` value on `line_out`, and position 11 puts the `natl_in` value. Each is sampled at the edge that ends that position.
- R9: `pay_in` has no effect on `line_out` at overhead positions 0 through 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Local line-rate transmit clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pay_in | input | 1 | Serial payload bit from upstream equipment |
| alarm_in | input | 1 | Value sent in the alarm overhead position |
| natl_in | input | 1 | Value sent in the national-use overhead position |
| line_out | output | 1 | Outbound frame bit stream, one clock latency |
| stall_ind | output | 1 | High one clock before each overhead position |
| frame_last | output | 1 | High while the last frame position is processed |

## Verification
The bench drives `pay_in` to the inverse of the overhead value in every overhead slot. A block that let payload leak into overhead therefore shows a flipped bit at once. The bench also walks across several frame boundaries. A counter that is off by one on the wrap shows a wrong spacing between frame pulses, or a stall indicator that starts late or ends late. A reset in the middle of a frame checks that counting restarts from position 0: a design that keeps its old position would pulse the frame marker too early. The alarm and national bits are changed between frames, which exposes a block that swaps those two slots or latches them at the wrong time.

// File: rtl/e3_tx_pkg.sv
// Shared types for the E3 transmit payload input.
// Assumes nothing; holds only the slot classification used across modules.
package e3_tx_pkg;
    typedef enum logic [1:0] {
        SLOT_FAS     = 2'd0,
        SLOT_ALARM   = 2'd1,
        SLOT_NATL    = 2'd2,
        SLOT_PAYLOAD = 2'd3
    } slot_kind_t;
endpackage

// File: rtl/e3_bit_counter.sv
// Frame position counter with registered indicator outputs.
// Assumes the overhead block sits at positions 0..OVH_BITS-1 of each frame.
module e3_bit_counter #(
    parameter int FRAME_BITS = 1536,
    parameter int OVH_BITS   = 12,
    parameter int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] pos,
    output logic             stall_ind,
    output logic             frame_last
);
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] OVH_TAIL = CNT_W'(OVH_BITS - 1);

    logic [CNT_W-1:0] pos_nxt;

    // Next position, wrapping at the end of the frame.
    always_comb begin
        pos_nxt = (pos == LAST) ? '0 : pos + 1'b1;
    end

    // Advance position and register indicators for the coming cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos        <= '0;
            stall_ind  <= 1'b0;
            frame_last <= 1'b0;
        end else begin
            pos        <= pos_nxt;
            stall_ind  <= (pos_nxt == LAST) || (pos_nxt < OVH_TAIL);
            frame_last <= (pos_nxt == LAST);
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pos == '0 && !stall_ind && !frame_last));
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == LAST) |=> (pos == '0));
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |=> !frame_last);
    a_r4_stall_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall_ind) |-> (pos == OVH_TAIL));
    a_r5_coincide: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |-> stall_ind);
endmodule

// File: rtl/e3_slot_decode.sv
// Classifies a frame position and supplies its overhead bit value.
// Assumes alignment word first (MSB first), then alarm, then national bit.
module e3_slot_decode
    import e3_tx_pkg::*;
#(
    parameter int          FAS_LEN  = 10,
    parameter logic [9:0]  FAS_WORD = 10'b1111010000,
    parameter int          CNT_W    = 11
) (
    input  logic [CNT_W-1:0] pos,
    input  logic             alarm_in,
    input  logic             natl_in,
    output slot_kind_t       kind,
    output logic             ovh_val
);
    localparam int IDX_W = $clog2(FAS_LEN);
    localparam logic [CNT_W-1:0] ALARM_POS = CNT_W'(FAS_LEN);
    localparam logic [CNT_W-1:0] NATL_POS  = CNT_W'(FAS_LEN + 1);
    localparam logic [CNT_W-1:0] FAS_END   = CNT_W'(FAS_LEN);

    logic [IDX_W-1:0] fas_idx;

    // Select slot type and overhead value for the current position.
    always_comb begin
        fas_idx = IDX_W'(FAS_LEN - 1) - pos[IDX_W-1:0];
        if (pos < FAS_END) begin
            kind    = SLOT_FAS;
            ovh_val = FAS_WORD[fas_idx];
        end else if (pos == ALARM_POS) begin
            kind    = SLOT_ALARM;
            ovh_val = alarm_in;
        end else if (pos == NATL_POS) begin
            kind    = SLOT_NATL;
            ovh_val = natl_in;
        end else begin
            kind    = SLOT_PAYLOAD;
            ovh_val = 1'b0;
        end
    end
endmodule

// File: rtl/e3_line_mux.sv
// Registers the outbound bit: overhead value or the sampled payload bit.
// Assumes the slot kind reflects the position being processed this cycle.
module e3_line_mux
    import e3_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  slot_kind_t kind,
    input  logic       ovh_val,
    input  logic       pay_in,
    output logic       line_out
);
    // Latch payload only in payload slots; overhead otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_out <= 1'b0;
        end else begin
            line_out <= (kind == SLOT_PAYLOAD) ? pay_in : ovh_val;
        end
    end
endmodule

// File: rtl/e3_tx_payload_in.sv
// E3 transmit serial payload input: counts frame positions, inserts
// overhead, samples payload and flags stalls and frame ends.
// Assumes one local clock for both this block and upstream equipment.
module e3_tx_payload_in
    import e3_tx_pkg::*;
#(
    parameter int         FRAME_BITS = 1536,
    parameter int         FAS_LEN    = 10,
    parameter logic [9:0] FAS_WORD   = 10'b1111010000
) (
    input  logic tx_clk,
    input  logic rst_n,
    input  logic pay_in,
    input  logic alarm_in,
    input  logic natl_in,
    output logic line_out,
    output logic stall_ind,
    output logic frame_last
);
    localparam int OVH_BITS = FAS_LEN + 2;
    localparam int CNT_W    = $clog2(FRAME_BITS);

    logic [CNT_W-1:0] pos;
    slot_kind_t       kind;
    logic             ovh_val;

    e3_bit_counter #(
        .FRAME_BITS(FRAME_BITS),
        .OVH_BITS  (OVH_BITS),
        .CNT_W     (CNT_W)
    ) u_counter (
        .clk       (tx_clk),
        .rst_n     (rst_n),
        .pos       (pos),
        .stall_ind (stall_ind),
        .frame_last(frame_last)
    );

    e3_slot_decode #(
        .FAS_LEN (FAS_LEN),
        .FAS_WORD(FAS_WORD),
        .CNT_W   (CNT_W)
    ) u_decode (
        .pos     (pos),
        .alarm_in(alarm_in),
        .natl_in (natl_in),
        .kind    (kind),
        .ovh_val (ovh_val)
    );

    e3_line_mux u_mux (
        .clk     (tx_clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .ovh_val (ovh_val),
        .pay_in  (pay_in),
        .line_out(line_out)
    );

    a_r4_stall_ahead: assert property (@(posedge tx_clk) disable iff (!rst_n)
        stall_ind |=> (kind != SLOT_PAYLOAD));
    a_r6_payload_pass: assert property (@(posedge tx_clk) disable iff (!rst_n)
        (kind == SLOT_PAYLOAD) |=> (line_out == $past(pay_in)));
    a_r8_alarm_slot: assert property (@(posedge tx_clk) disable iff (!rst_n)
        (kind == SLOT_ALARM) |=> (line_out == $past(alarm_in)));
endmodule

// File: tb/test_e3_tx_payload_in.sv
module test_e3_tx_payload_in;
    localparam int  N    = 1536;
    localparam time HALF = 2.5ns;

    logic tx_clk = 1'b0;
    logic rst_n = 1'b0, pay_in = 1'b0, alarm_in = 1'b0, natl_in = 1'b0;
    logic line_out, stall_ind, frame_last;

    int  total = 0, bad = 0;
    int  bpos = 0, cyc = 0, last_fe = -1;
    bit  done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #HALF tx_clk = ~tx_clk;

    e3_tx_payload_in i_e3_tx_payload_in (
        .tx_clk(tx_clk), .rst_n(rst_n), .pay_in(pay_in),
        .alarm_in(alarm_in), .natl_in(natl_in),
        .line_out(line_out), .stall_ind(stall_ind), .frame_last(frame_last)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s pos=%0d actual=%b expected=%b", tag, bpos, act, exp);
        end
    endtask

    function automatic logic ovh_bit(input int p, input logic al, input logic na);
        logic [9:0] fas = 10'b1111010000;
        if (p < 10) return fas[9 - p];
        if (p == 10) return al;
        return na;
    endfunction

    // One clock: drive at negedge, sample at the next negedge.
    task automatic step(input logic rst, input logic din, input logic al, input logic na);
        int   np;
        logic e_line;
        rst_n = rst; pay_in = din; alarm_in = al; natl_in = na;
        @(posedge tx_clk);
        @(negedge tx_clk);
        cyc++;
        if (!rst) begin
            chk("R1 line_out", line_out, 1'b0);
            chk("R1 stall_ind", stall_ind, 1'b0);
            chk("R1 frame_last", frame_last, 1'b0);
            bpos = 0; last_fe = -1;
            return;
        end
        e_line = (bpos < 12) ? ovh_bit(bpos, al, na) : din;
        if (bpos < 10)      chk("R7/R9 alignment bit", line_out, e_line);
        else if (bpos < 12) chk("R8/R9 alarm-natl bit", line_out, e_line);
        else                chk("R6 payload bit", line_out, e_line);
        np = (bpos == N - 1) ? 0 : bpos + 1;
        bpos = np;
        chk("R4 stall_ind", stall_ind, (np == N - 1) || (np < 11));
        chk("R3 frame_last", frame_last, np == N - 1);
        if (frame_last === 1'b1) begin
            chk("R5 stall with frame_last", stall_ind, 1'b1);
            if (last_fe >= 0) begin
                total++;
                if (cyc - last_fe != N) begin
                    bad++;
                    $display("FAIL R2 spacing actual=%0d expected=%0d", cyc - last_fe, N);
                end
            end
            last_fe = cyc;
        end
    endtask

    task automatic t_reset(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b1, 1'b1);
    endtask

    // Run whole-position steps with a payload pattern; overhead slots get the
    // inverse of the overhead value on pay_in (R9).
    task automatic t_run(input int mode, input logic al, input logic na, input int nsteps);
        for (int i = 0; i < nsteps; i++) begin
            logic d;
            case (mode)
                0: d = 1'b0;
                1: d = 1'b1;
                2: d = bpos[0];
                default: begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    d = lfsr[0];
                end
            endcase
            if (bpos < 12) d = ~ovh_bit(bpos, al, na);
            step(1'b1, d, al, na);
        end
    endtask

    task automatic t_first_frame_timing;
        int seen;
        seen = 0;
        for (int i = 1; i <= N; i++) begin
            step(1'b1, 1'b1, 1'b0, 1'b1);
            if (frame_last === 1'b1 && seen == 0) begin
                seen = i;
            end
        end
        chk("R3 first pulse at clock 1535", seen == N - 1, 1'b1);
    endtask

    task automatic t_midframe_reset;
        t_run(3, 1'b1, 1'b0, 700);
        t_reset(2);
        t_first_frame_timing();
    endtask

    initial begin
        @(negedge tx_clk);
        t_reset(3);
        t_first_frame_timing();
        t_run(0, 1'b0, 1'b0, N);
        t_run(1, 1'b1, 1'b0, N);
        t_run(2, 1'b0, 1'b1, N);
        t_run(3, 1'b1, 1'b1, N + 40);
        t_midframe_reset();
        t_run(3, 1'b0, 1'b1, 200);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(HALF * 2 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule